// File: doc/BRIEF.md
# Multicore coherency unit register block

This block is the register file of a snoop-control style unit that serves up to four processor cores. It has no snoop traffic and no coherency datapath. A simple register bus gives it a byte offset, a read/write flag, an access size of 1, 2 or 4 bytes and 32 bits of write data. The block decodes the offset and does one of the following:

- updates or returns a one-bit enable,
- returns a read-only configuration word built from the core count,
- reads or byte-merges a 32-bit power-status word,
- treats the offset as a read-as-zero placeholder that ignores writes.

A write takes effect on the clock edge that samples the request. A read response, with its valid strobe, appears one clock after the request. An error strobe marks undecoded offsets and illegal access sizes.

Top module: `cu_regblk`

## Requirements
- R1: While reset is high, and after it is released, the enable bit and the power-status word are zero, and `rd_valid` and `err` are low.
- R2: A write to offset 0x00 stores only bit 0 of `req_wdata`. A read of 0x00 returns that bit in bit 0, with all other bits zero.
- R3: Offset 0x04 reads `(((1 << NUM_CORES) - 1) << 4) | (NUM_CORES - 1)`. Writes to 0x04 change nothing.
- R4: A read at offset 0x08+k, for k from 0 to 3, returns the power-status word shifted right by 8*k bits, with zeros filled in from the top.
- R5: A write at 0x08+k builds a size mask: 0xFF when `req_size`=1, 0xFFFF when 2, 0xFFFFFFFF when 4. The mask is shifted left by 8*k and cut to 32 bits. The masked bits of the word take the masked data (data ANDed with the size mask, then shifted left by 8*k). All other bits are kept.
- R6: Offsets 0x0C, 0x40, 0x44, 0x50 and 0x54 read as zero, change no state on a write, and do not raise `err`.
- R7: Any other offset reads as zero, changes no state, and raises `err` for exactly one cycle.
- R8: A `req_size` value other than 1, 2 or 4 raises `err`, changes no state, and a read with that size returns zero.
- R9: `rd_valid` and `rd_data` appear in the cycle after a read request and last one cycle. Writes never raise `rd_valid`. A read issued after a write returns the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset |
| req_size | input | 3 | Access size in bytes (1, 2 or 4 legal) |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read response valid, one cycle after the read |
| rd_data | output | 32 | Read response data |
| err | output | 1 | Undecoded offset or illegal size, one cycle after the request |

## Verification
The bench builds the block with `NUM_CORES`=3 and `ADDR_W`=8. With three cores the configuration word is 0x72: the core bitmap and the count field are both non-trivial, so a wrong shift or a missing minus-one shows up. The default of one core would give only 0x10. The 8-bit offset space lets random offsets hit the undecoded holes between the decoded registers. Every byte lane of the power word is reachable with every legal size, including writes at 0x0A and 0x0B whose masks run past bit 31.

// File: rtl/cu_regs_pkg.sv
package cu_regs_pkg;

    localparam int DATA_W = 32;

    localparam int OFF_CTRL  = 'h00;
    localparam int OFF_CFG   = 'h04;
    localparam int OFF_PWR   = 'h08;
    localparam int OFF_INV   = 'h0C;
    localparam int OFF_FLT_S = 'h40;
    localparam int OFF_FLT_E = 'h44;
    localparam int OFF_ACC_S = 'h50;
    localparam int OFF_ACC_N = 'h54;

    typedef enum logic [2:0] {
        SEL_CTRL,
        SEL_CFG,
        SEL_PWR,
        SEL_RAZ,
        SEL_BAD
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e   sel;
        logic [1:0] lane;
        logic       size_ok;
    } dec_t;

    function automatic logic size_legal(input logic [2:0] sz);
        return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
    endfunction

    function automatic logic [DATA_W-1:0] size_mask(input logic [2:0] sz);
        logic [DATA_W-1:0] m;
        case (sz)
            3'd1:    m = 32'h0000_00FF;
            3'd2:    m = 32'h0000_FFFF;
            3'd4:    m = 32'hFFFF_FFFF;
            default: m = '0;
        endcase
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] cfg_word(input int n);
        logic [DATA_W-1:0] w;
        w = ((DATA_W'(1) << n) - DATA_W'(1)) << 4;
        w = w | DATA_W'(n - 1);
        return w;
    endfunction

endpackage

// File: rtl/cu_addr_decode.sv
module cu_addr_decode
    import cu_regs_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        size,
    output dec_t              dec
);

    localparam int UPPER_W = ADDR_W - 2;

    logic is_raz;

    always_comb begin
        is_raz = (addr == ADDR_W'(OFF_INV))   || (addr == ADDR_W'(OFF_FLT_S)) ||
                 (addr == ADDR_W'(OFF_FLT_E)) || (addr == ADDR_W'(OFF_ACC_S)) ||
                 (addr == ADDR_W'(OFF_ACC_N));
    end

    always_comb begin
        dec.size_ok = size_legal(size);
        dec.lane    = addr[1:0];
        if (addr == ADDR_W'(OFF_CTRL)) begin
            dec.sel = SEL_CTRL;
        end else if (addr == ADDR_W'(OFF_CFG)) begin
            dec.sel = SEL_CFG;
        end else if (addr[ADDR_W-1:2] == UPPER_W'(OFF_PWR >> 2)) begin
            dec.sel = SEL_PWR;
        end else if (is_raz) begin
            dec.sel = SEL_RAZ;
        end else begin
            dec.sel = SEL_BAD;
        end
    end

endmodule

// File: rtl/cu_pwr_word.sv
module cu_pwr_word
    import cu_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        lane,
    input  logic [2:0]        size,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] word
);

    logic [DATA_W-1:0] lane_m;
    logic [DATA_W-1:0] lane_d;

    always_comb begin
        lane_m = size_mask(size) << {lane, 3'b000};
        lane_d = (wdata & size_mask(size)) << {lane, 3'b000};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word <= '0;
        end else if (wr_en) begin
            word <= (word & ~lane_m) | lane_d;
        end
    end

    // R5
    keep_unmasked_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (((word ^ $past(word)) & ~$past(lane_m)) == '0));

    // R5
    idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(word));

endmodule

// File: rtl/cu_resp_stage.sv
module cu_resp_stage
    import cu_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_fire,
    input  logic              err_fire,
    input  logic [DATA_W-1:0] rd_word,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              err
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            err      <= 1'b0;
        end else begin
            rd_valid <= rd_fire;
            rd_data  <= rd_fire ? rd_word : '0;
            err      <= err_fire;
        end
    end

    // R9
    rd_follow_chk: assert property (@(posedge clk) disable iff (rst)
        rd_fire |=> rd_valid);

    // R9
    quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_fire && !err_fire) |=> (!rd_valid && !err && rd_data == '0));

endmodule

// File: rtl/cu_regblk.sv
module cu_regblk
    import cu_regs_pkg::*;
#(
    parameter int NUM_CORES = 1,
    parameter int ADDR_W    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_size,
    input  logic [31:0]       req_wdata,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    output logic              err
);

    localparam logic [DATA_W-1:0] CFG_VAL = cfg_word(NUM_CORES);

    dec_t              dec;
    logic              ctrl_q;
    logic [DATA_W-1:0] pwr_q;
    logic [DATA_W-1:0] rd_mux;
    logic              wr_ok;
    logic              rd_fire;
    logic              err_fire;
    logic              pwr_wr;
    logic              ctrl_wr;

    cu_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (req_addr),
        .size (req_size),
        .dec  (dec)
    );

    always_comb begin
        wr_ok    = req_valid && req_write && dec.size_ok;
        pwr_wr   = wr_ok && (dec.sel == SEL_PWR);
        ctrl_wr  = wr_ok && (dec.sel == SEL_CTRL);
        rd_fire  = req_valid && !req_write;
        err_fire = req_valid && (!dec.size_ok || dec.sel == SEL_BAD);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= 1'b0;
        end else if (ctrl_wr) begin
            ctrl_q <= req_wdata[0];
        end
    end

    cu_pwr_word u_pwr (
        .clk   (clk),
        .rst   (rst),
        .wr_en (pwr_wr),
        .lane  (dec.lane),
        .size  (req_size),
        .wdata (req_wdata),
        .word  (pwr_q)
    );

    always_comb begin
        rd_mux = '0;
        if (dec.size_ok) begin
            case (dec.sel)
                SEL_CTRL: rd_mux = {{(DATA_W-1){1'b0}}, ctrl_q};
                SEL_CFG:  rd_mux = CFG_VAL;
                SEL_PWR:  rd_mux = pwr_q >> {dec.lane, 3'b000};
                default:  rd_mux = '0;
            endcase
        end
    end

    cu_resp_stage u_resp (
        .clk      (clk),
        .rst      (rst),
        .rd_fire  (rd_fire),
        .err_fire (err_fire),
        .rd_word  (rd_mux),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .err      (err)
    );

    // R2
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_write && req_addr == ADDR_W'(OFF_CTRL)) |=> $stable(ctrl_q));

    // R8
    bad_size_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !size_legal(req_size)) |=> (err && $stable(pwr_q) && $stable(ctrl_q)));

    // R6
    raz_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && dec.size_ok && dec.sel == SEL_RAZ) |=> (!err && rd_data == '0));

endmodule

// File: tb/tb_cu_regblk.sv
module tb_cu_regblk;

    localparam int CLK_PERIOD = 10;
    localparam int CORES      = 3;
    localparam int AW         = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr  = '0;
    logic [2:0]    req_size  = 3'd4;
    logic [31:0]   req_wdata = '0;
    logic          rd_valid;
    logic [31:0]   rd_data;
    logic          err;

    int n_chk  = 0;
    int n_fail = 0;

    logic        m_ctrl = 1'b0;
    logic [31:0] m_pwr  = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cu_regblk #(.NUM_CORES(CORES), .ADDR_W(AW)) dut (
        .clk, .rst, .req_valid, .req_write, .req_addr, .req_size,
        .req_wdata, .rd_valid, .rd_data, .err
    );

    task automatic check(input logic ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic ok_size(input logic [2:0] s);
        return s == 3'd1 || s == 3'd2 || s == 3'd4;
    endfunction

    function automatic logic [31:0] mk_mask(input logic [2:0] s);
        return s == 3'd1 ? 32'hFF : s == 3'd2 ? 32'hFFFF : s == 3'd4 ? 32'hFFFF_FFFF : 32'h0;
    endfunction

    function automatic logic is_raz(input logic [AW-1:0] a);
        return a == 8'h0C || a == 8'h40 || a == 8'h44 || a == 8'h50 || a == 8'h54;
    endfunction

    function automatic logic is_known(input logic [AW-1:0] a);
        return a == 8'h00 || a == 8'h04 || (a >= 8'h08 && a <= 8'h0B) || is_raz(a);
    endfunction

    function automatic logic [31:0] exp_cfg();
        return (((32'd1 << CORES) - 32'd1) << 4) | 32'(CORES - 1);
    endfunction

    function automatic logic [31:0] exp_read(input logic [AW-1:0] a, input logic [2:0] s);
        if (!ok_size(s)) return 32'h0;
        if (a == 8'h00) return {31'h0, m_ctrl};
        if (a == 8'h04) return exp_cfg();
        if (a >= 8'h08 && a <= 8'h0B) return m_pwr >> (8 * int'(a - 8'h08));
        return 32'h0;
    endfunction

    function automatic string tag_of(input logic [AW-1:0] a, input logic [2:0] s);
        if (!ok_size(s)) return "R8";
        if (a == 8'h00) return "R2";
        if (a == 8'h04) return "R3";
        if (a >= 8'h08 && a <= 8'h0B) return "R4/R5";
        if (is_raz(a)) return "R6";
        return "R7";
    endfunction

    task automatic access(input logic wr, input logic [AW-1:0] a, input logic [2:0] s,
                          input logic [31:0] d);
        logic [31:0] exp_d;
        logic        exp_e;
        string       tg;
        @(negedge clk);
        check(!rd_valid && !err, "R9 strobes idle before request", {30'h0, rd_valid, err}, 32'h0);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = s; req_wdata = d;
        exp_d = exp_read(a, s);
        exp_e = !ok_size(s) || !is_known(a);
        tg    = tag_of(a, s);
        @(posedge clk); #1;
        if (wr) begin
            check(!rd_valid, {"R9 no rd_valid on write ", tg}, {31'h0, rd_valid}, 32'h0);
            if (ok_size(s) && a == 8'h00) m_ctrl = d[0];
            if (ok_size(s) && a >= 8'h08 && a <= 8'h0B) begin
                int sh = 8 * int'(a - 8'h08);
                m_pwr = (m_pwr & ~(mk_mask(s) << sh)) | ((d & mk_mask(s)) << sh);
            end
        end else begin
            check(rd_valid, {"R9 rd_valid ", tg}, {31'h0, rd_valid}, 32'h1);
            check(rd_data == exp_d, {"read data ", tg}, rd_data, exp_d);
        end
        check(err == exp_e, {"err ", tg}, {31'h0, err}, {31'h0, exp_e});
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        // R1 outputs quiet in reset
        check(!rd_valid && !err && rd_data == 0, "R1 reset outputs", rd_data, 32'h0);
        @(negedge clk); rst = 1'b0;
        // R1 state cleared
        access(1'b0, 8'h00, 3'd4, 0);
        access(1'b0, 8'h08, 3'd4, 0);
        // R3 configuration word and write-ignore
        access(1'b0, 8'h04, 3'd4, 0);
        check(exp_cfg() == 32'h72, "R3 formula for three cores", exp_cfg(), 32'h72);
        access(1'b1, 8'h04, 3'd4, 32'hFFFF_FFFF);
        access(1'b0, 8'h04, 3'd4, 0);
        // R2 only bit 0 stored
        access(1'b1, 8'h00, 3'd4, 32'hFFFF_FFFE);
        access(1'b0, 8'h00, 3'd4, 0);
        access(1'b1, 8'h00, 3'd1, 32'h0000_0003);
        access(1'b0, 8'h00, 3'd4, 0);
        // R5 lane masks, including masks past bit 31
        access(1'b1, 8'h08, 3'd4, 32'h1122_3344);
        access(1'b1, 8'h0B, 3'd4, 32'hAABB_CCDD);
        access(1'b1, 8'h0A, 3'd2, 32'h5566_7788);
        access(1'b1, 8'h09, 3'd1, 32'hFFFF_FF99);
        for (int k = 0; k < 4; k++) access(1'b0, AW'(8 + k), 3'd4, 0);   // R4
        // R8 illegal sizes leave state alone
        access(1'b1, 8'h08, 3'd3, 32'h0);
        access(1'b1, 8'h00, 3'd0, 32'h0);
        access(1'b0, 8'h08, 3'd7, 0);
        access(1'b0, 8'h08, 3'd4, 0);
        // R6 and R7
        access(1'b1, 8'h40, 3'd4, 32'hDEAD_BEEF);
        access(1'b0, 8'h40, 3'd4, 0);
        access(1'b1, 8'h01, 3'd1, 32'hFF);
        access(1'b0, 8'h01, 3'd1, 0);
        access(1'b0, 8'h00, 3'd4, 0);
        // constrained random mix
        for (int i = 0; i < 400; i++) begin
            logic [AW-1:0] a;
            logic [2:0]    s;
            int            r;
            r = $urandom_range(0, 13);
            case (r)
                0: a = 8'h00; 1: a = 8'h04; 2: a = 8'h08; 3: a = 8'h09;
                4: a = 8'h0A; 5: a = 8'h0B; 6: a = 8'h0C; 7: a = 8'h40;
                8: a = 8'h44; 9: a = 8'h50; 10: a = 8'h54; 11: a = 8'h10;
                12: a = 8'h02;
                default: a = AW'($urandom);
            endcase
            r = $urandom_range(0, 9);
            s = r < 3 ? 3'd1 : r < 6 ? 3'd2 : r < 9 ? 3'd4 : 3'($urandom_range(5, 7));
            access(1'($urandom), a, s, $urandom);
        end
        @(negedge clk);
        check(!rd_valid && !err, "R9 strobes single cycle", {30'h0, rd_valid, err}, 32'h0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule